// File: doc/BRIEF.md
# Vernier Time-to-Digital Converter Controller

This block finds where an asynchronous trigger falls inside one period of the reference clock. It uses two free-running ring oscillators whose periods differ slightly. The trigger's rising edge starts the slower oscillator. The next rising edge of the reference clock starts the faster one. The controller counts the rising edges of each oscillator. A phase detector, outside the block, reports when a fast edge has reached or passed the slow edge of the same index. At that point both oscillators stop and both counts freeze.

The two counts are the vernier result. With slow period Ts, fast period Tf and step Δ = Ts − Tf, the trigger-to-reference interval is (slow count − fast count)·Ts + fast count·Δ. The longest conversion, and so the dead time, grows with Ts/Δ. Only the stop flag crosses into the reference domain, through a flop synchronizer. The frozen counts are then captured there and held behind a ready flag until software-side logic pulses clear. If no coincidence arrives in time, a watchdog in the reference domain ends the attempt and flags an error. Triggers that arrive while the block is not armed are dropped and counted.

Top module: `vernier_tdc`

## Requirements
- R1: While rst_ni is low and just after it rises, ready_o, tmo_err_o, slow_en_o and fast_en_o are 0, and slow_cnt_o, fast_cnt_o and miss_cnt_o are 0.
- R2: When the block is armed, a rising edge on trig_i raises slow_en_o at once. fast_en_o stays low until the next rising edge of clk_i and is high right after it.
- R3: slow_cnt_o reports the number of slow_clk_i rising edges seen while slow_en_o was high. fast_cnt_o reports the number of fast_clk_i rising edges seen while fast_en_o was high and coinc_i was low. A fast_clk_i rising edge that samples coinc_i high ends the conversion and drops both enables.
- R4: After a coincidence, ready_o rises within a few clk_i cycles with tmo_err_o low. With oscillators that start half a period after their enable, both counts equal ceil((e − (Ts − Tf)/2)/Δ), floored at 0, where e is the time from the trigger edge to the next clk_i rising edge.
- R5: While ready_o is high and clear_i is low, ready_o, tmo_err_o and both counts hold. A clk_i edge that samples clear_i high drops ready_o after that edge. The block is armed again one cycle later.
- R6: If no coincidence is seen, ready_o and tmo_err_o rise at the TMO_CYCLES-th (default 64) rising edge of clk_i after the trigger and not before. Both enables then drop and both counts read 0.
- R7: Clearing an error result drops tmo_err_o, and the next trigger converts normally.
- R8: A trigger that arrives during a conversion or while ready_o is high changes neither the enables, nor the result, nor ready_o. Each such trigger raises miss_cnt_o by one.
- R9: miss_cnt_o saturates at 2^MISS_W − 1 (15 by default). Only rst_ni clears it.
- R10: fast_en_o is never high while slow_en_o is low, and neither enable is high while ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Asynchronous trigger; its rising edge starts a conversion |
| slow_clk_i | input | 1 | Output of the slow ring oscillator |
| fast_clk_i | input | 1 | Output of the fast ring oscillator |
| coinc_i | input | 1 | Registered phase-detector output; high when the fast edge has caught the slow edge |
| clear_i | input | 1 | Releases a held result and re-arms the block (clk_i domain) |
| slow_en_o | output | 1 | Enable for the slow oscillator |
| fast_en_o | output | 1 | Enable for the fast oscillator |
| ready_o | output | 1 | A result or an error is held |
| tmo_err_o | output | 1 | The held result is a timeout |
| slow_cnt_o | output | CNT_W | Slow-oscillator count of the held result |
| fast_cnt_o | output | CNT_W | Fast-oscillator count of the held result |
| miss_cnt_o | output | MISS_W | Saturating count of ignored triggers |

## Verification
The hardest case to reach from the ports is the exact catch-up point. It depends on the trigger's sub-period position against clk_i and on both oscillators starting from their enables. To get there, the bench itself acts as both oscillators and the phase detector. It launches each one half a period after its enable rises, and it raises coinc_i just before the first fast edge that lands at or before its slow counterpart. The trigger offset is then swept across the whole reference period. The step is chosen so that no slow edge and fast edge ever coincide in time, which gives every offset a single exact count. The timeout is reached by turning the phase-detector model off.

// File: rtl/vtdc_pkg.sv
`timescale 1ps/1ps
package vtdc_pkg;
  typedef enum logic [1:0] {
    ST_ARM   = 2'd0,
    ST_DONE  = 2'd1,
    ST_FLUSH = 2'd2
  } vtdc_state_e;
endpackage

// File: rtl/vtdc_osc_counter.sv
`timescale 1ps/1ps
module vtdc_osc_counter #(
  parameter int W = 8
) (
  input  logic         osc_clk_i,
  input  logic         arst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CntMax = '1;

  always_ff @(posedge osc_clk_i or negedge arst_ni) begin
    if (!arst_ni)                      cnt_o <= '0;
    else if (inc_i && cnt_o != CntMax) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/vtdc_sync.sv
`timescale 1ps/1ps
module vtdc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) pipe_q <= '0;
    else          pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/vtdc_trig_stage.sv
`timescale 1ps/1ps
module vtdc_trig_stage #(
  parameter int MISS_W = 4
) (
  input  logic              trig_i,
  input  logic              rst_ni,
  input  logic              flush_ni,
  output logic              hit_o,
  output logic [MISS_W-1:0] miss_cnt_o
);
  localparam logic [MISS_W-1:0] MissMax = '1;

  // first accepted edge latches; flush re-arms
  always_ff @(posedge trig_i or negedge flush_ni) begin
    if (!flush_ni) hit_o <= 1'b0;
    else           hit_o <= 1'b1;
  end

  // an edge seeing hit already set was not accepted
  always_ff @(posedge trig_i or negedge rst_ni) begin
    if (!rst_ni)                              miss_cnt_o <= '0;
    else if (hit_o && miss_cnt_o != MissMax)  miss_cnt_o <= miss_cnt_o + 1'b1;
  end
endmodule

// File: rtl/vernier_tdc.sv
`timescale 1ps/1ps
module vernier_tdc
  import vtdc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int MISS_W      = 4,
  parameter int TMO_CYCLES  = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic              slow_clk_i,
  input  logic              fast_clk_i,
  input  logic              coinc_i,
  input  logic              clear_i,
  output logic              slow_en_o,
  output logic              fast_en_o,
  output logic              ready_o,
  output logic              tmo_err_o,
  output logic [CNT_W-1:0]  slow_cnt_o,
  output logic [CNT_W-1:0]  fast_cnt_o,
  output logic [MISS_W-1:0] miss_cnt_o
);
  localparam int TMO_W = (TMO_CYCLES > 1) ? $clog2(TMO_CYCLES) : 1;
  localparam logic [TMO_W-1:0] TmoLast = TMO_W'(TMO_CYCLES - 1);

  vtdc_state_e       state_q;
  logic              flush_n;
  logic              armed;
  logic              hit;
  logic              fast_go_q;
  logic              stop_q;
  logic              stop_s;
  logic [TMO_W-1:0]  tmo_q;
  logic              tmo_run;
  logic [1:0]        osc_clk;
  logic [1:0]        osc_inc;
  logic [CNT_W-1:0]  osc_cnt [2];

  assign armed   = (state_q == ST_ARM);
  // one-cycle local reset of every conversion flop on re-arm
  assign flush_n = rst_ni & (state_q != ST_FLUSH);

  vtdc_trig_stage #(.MISS_W(MISS_W)) u_trig (
    .trig_i     (trig_i),
    .rst_ni     (rst_ni),
    .flush_ni   (flush_n),
    .hit_o      (hit),
    .miss_cnt_o (miss_cnt_o)
  );

  // fast oscillator launches on the first reference edge after the trigger
  always_ff @(posedge clk_i or negedge flush_n) begin
    if (!flush_n)  fast_go_q <= 1'b0;
    else if (hit)  fast_go_q <= 1'b1;
  end

  // coincidence registered on the fast oscillator edge
  always_ff @(posedge fast_clk_i or negedge flush_n) begin
    if (!flush_n)                  stop_q <= 1'b0;
    else if (fast_en_o && coinc_i) stop_q <= 1'b1;
  end

  assign slow_en_o = hit       & ~stop_q & armed;
  assign fast_en_o = fast_go_q & ~stop_q & armed;

  assign osc_clk = {fast_clk_i, slow_clk_i};
  assign osc_inc = {fast_en_o & ~coinc_i, slow_en_o};

  for (genvar g = 0; g < 2; g++) begin : g_osc
    vtdc_osc_counter #(.W(CNT_W)) u_cnt (
      .osc_clk_i (osc_clk[g]),
      .arst_ni   (flush_n),
      .inc_i     (osc_inc[g]),
      .cnt_o     (osc_cnt[g])
    );
  end

  // counts are frozen once stop_q is set; only the flag crosses
  vtdc_sync #(.STAGES(SYNC_STAGES)) u_stop_sync (
    .clk_i   (clk_i),
    .arst_ni (flush_n),
    .d_i     (stop_q),
    .q_o     (stop_s)
  );

  assign tmo_run = armed & hit & ~stop_s;

  always_ff @(posedge clk_i or negedge flush_n) begin
    if (!flush_n)     tmo_q <= '0;
    else if (tmo_run) tmo_q <= tmo_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_ARM;
      tmo_err_o  <= 1'b0;
      slow_cnt_o <= '0;
      fast_cnt_o <= '0;
    end else begin
      unique case (state_q)
        ST_ARM: begin
          if (stop_s) begin
            state_q    <= ST_DONE;
            tmo_err_o  <= 1'b0;
            slow_cnt_o <= osc_cnt[0];
            fast_cnt_o <= osc_cnt[1];
          end else if (tmo_run && tmo_q == TmoLast) begin
            state_q    <= ST_DONE;
            tmo_err_o  <= 1'b1;
            slow_cnt_o <= '0;
            fast_cnt_o <= '0;
          end
        end
        ST_DONE: begin
          if (clear_i) begin
            state_q   <= ST_FLUSH;
            tmo_err_o <= 1'b0;
          end
        end
        ST_FLUSH: state_q <= ST_ARM;
        default:  state_q <= ST_ARM;
      endcase
    end
  end

  assign ready_o = (state_q == ST_DONE);
endmodule

// File: rtl/vernier_tdc_chk.sv
`timescale 1ps/1ps
module vernier_tdc_chk #(
  parameter int CNT_W  = 8,
  parameter int MISS_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              slow_en_o,
  input logic              fast_en_o,
  input logic              ready_o,
  input logic              tmo_err_o,
  input logic [CNT_W-1:0]  slow_cnt_o,
  input logic [CNT_W-1:0]  fast_cnt_o,
  input logic [MISS_W-1:0] miss_cnt_o
);
  p_err_only_when_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_err_o |-> ready_o);

  p_err_counts_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_err_o |-> (slow_cnt_o == '0 && fast_cnt_o == '0));

  p_osc_off_when_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!slow_en_o && !fast_en_o));

  p_fast_needs_slow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_en_o |-> slow_en_o);

  p_hold_until_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !clear_i) |=> (ready_o && $stable(slow_cnt_o) && $stable(fast_cnt_o)
                               && $stable(tmo_err_o)));

  p_clear_releases_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && clear_i) |=> (!ready_o && !tmo_err_o));

  p_miss_monotone_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_cnt_o >= $past(miss_cnt_o));
endmodule

bind vernier_tdc vernier_tdc_chk #(.CNT_W(CNT_W), .MISS_W(MISS_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clear_i    (clear_i),
  .slow_en_o  (slow_en_o),
  .fast_en_o  (fast_en_o),
  .ready_o    (ready_o),
  .tmo_err_o  (tmo_err_o),
  .slow_cnt_o (slow_cnt_o),
  .fast_cnt_o (fast_cnt_o),
  .miss_cnt_o (miss_cnt_o)
);

// File: tb/vernier_tdc_tb.sv
`timescale 1ps/1ps
module vernier_tdc_tb;
  localparam int CNT_W  = 8;
  localparam int MISS_W = 4;
  localparam int TMO    = 64;
  localparam int CLK_PS = 8000;
  localparam int T0_PS  = 2200;
  localparam int T1_PS  = 2000;
  localparam int DT_PS  = T0_PS - T1_PS;

  logic clk_i = 1'b0, rst_ni = 1'b0, trig_i = 1'b0;
  logic slow_clk_i = 1'b0, fast_clk_i = 1'b0, coinc_i = 1'b0, clear_i = 1'b0;
  logic slow_en_o, fast_en_o, ready_o, tmo_err_o;
  logic [CNT_W-1:0]  slow_cnt_o, fast_cnt_o;
  logic [MISS_W-1:0] miss_cnt_o;

  int  n_chk = 0, n_fail = 0;
  bit  pd_on = 1'b1;
  longint t_slow = 0;

  vernier_tdc #(.CNT_W(CNT_W), .MISS_W(MISS_W), .TMO_CYCLES(TMO)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig_i),
    .slow_clk_i(slow_clk_i), .fast_clk_i(fast_clk_i), .coinc_i(coinc_i),
    .clear_i(clear_i), .slow_en_o(slow_en_o), .fast_en_o(fast_en_o),
    .ready_o(ready_o), .tmo_err_o(tmo_err_o), .slow_cnt_o(slow_cnt_o),
    .fast_cnt_o(fast_cnt_o), .miss_cnt_o(miss_cnt_o)
  );

  always #(CLK_PS/2) clk_i = ~clk_i;

  // slow ring oscillator model: first rise half a period after enable
  initial forever begin
    @(posedge slow_en_o);
    t_slow = $time;
    while (slow_en_o) begin
      #(T0_PS/2);
      if (slow_en_o) slow_clk_i = 1'b1;
      #(T0_PS/2) slow_clk_i = 1'b0;
    end
  end

  // fast ring oscillator plus phase detector model
  initial forever begin
    longint t_fast;
    int k;
    @(posedge fast_en_o);
    t_fast = $time;
    k = 0;
    while (fast_en_o) begin
      #(T1_PS/2 - 1);
      coinc_i = pd_on && ((t_fast + T1_PS/2 + k*T1_PS) <= (t_slow + T0_PS/2 + k*T0_PS));
      #1;
      if (fast_en_o) fast_clk_i = 1'b1;
      k++;
      #(T1_PS/2) fast_clk_i = 1'b0;
    end
    coinc_i = 1'b0;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_steps(input int e);
    int d;
    d = e - DT_PS/2;
    if (d <= 0) return 0;
    return (d + DT_PS - 1) / DT_PS;
  endfunction

  // trigger e ps before a clk rising edge; checks launch order (R2)
  task automatic fire(input int e);
    @(posedge clk_i);
    #(CLK_PS - e);
    trig_i = 1'b1;
    #1;
    chk("R2 slow_en on trigger", slow_en_o, 1);
    chk("R2 fast_en waits", fast_en_o, 0);
    @(posedge clk_i);
    #1;
    chk("R2 fast_en after clk", fast_en_o, 1);
    trig_i = 1'b0;
  endtask

  task automatic pulse_trig();
    trig_i = 1'b1;
    #1000;
    trig_i = 1'b0;
    #1000;
  endtask

  task automatic wait_ready(input string req);
    int i;
    i = 0;
    while (!ready_o && i < 100) begin
      @(negedge clk_i);
      i++;
    end
    chk(req, ready_o, 1);
  endtask

  task automatic do_clear();
    @(negedge clk_i);
    clear_i = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0;
    chk("R5 ready drops after clear", ready_o, 0);
    chk("R7 err drops after clear", tmo_err_o, 0);
    @(negedge clk_i);
  endtask

  initial begin
    #800_000_000;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int js;
    logic [CNT_W-1:0] s0, f0;
    // R1 reset state
    #3000;
    chk("R1 ready", ready_o, 0);
    chk("R1 err", tmo_err_o, 0);
    chk("R1 slow_en", slow_en_o, 0);
    chk("R1 fast_en", fast_en_o, 0);
    chk("R1 miss", miss_cnt_o, 0);
    chk("R1 slow_cnt", slow_cnt_o, 0);
    chk("R1 fast_cnt", fast_cnt_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 ready after release", ready_o, 0);

    // R3 R4: sweep the trigger across the reference period
    for (int m = 0; m < 32; m++) begin
      int e;
      e  = 250*m + 30;
      js = exp_steps(e);
      fire(e);
      wait_ready("R4 ready after coincidence");
      chk("R4 no error", tmo_err_o, 0);
      chk("R3 slow count", slow_cnt_o, js);
      chk("R3 fast count", fast_cnt_o, js);
      chk("R3 enables off", {slow_en_o, fast_en_o}, 0);
      do_clear();
    end
    chk("R8 no misses in sweep", miss_cnt_o, 0);

    // R8: second trigger during a long conversion
    js = exp_steps(7780);
    fire(7780);
    #20000;
    pulse_trig();
    chk("R8 miss during conversion", miss_cnt_o, 1);
    wait_ready("R8 ready");
    chk("R8 slow count kept", slow_cnt_o, js);
    chk("R8 fast count kept", fast_cnt_o, js);

    // R8 R5: trigger while the result is held
    s0 = slow_cnt_o;
    f0 = fast_cnt_o;
    @(negedge clk_i);
    pulse_trig();
    chk("R8 miss while ready", miss_cnt_o, 2);
    repeat (3) @(negedge clk_i);
    chk("R5 ready held", ready_o, 1);
    chk("R5 slow held", slow_cnt_o, s0);
    chk("R5 fast held", fast_cnt_o, f0);
    chk("R8 enables stay off", {slow_en_o, fast_en_o}, 0);
    do_clear();

    // R6: no coincidence -> timeout at the TMO-th edge
    pd_on = 1'b0;
    fire(4030);
    repeat (TMO - 2) @(posedge clk_i);
    #100;
    chk("R6 not before timeout", ready_o, 0);
    @(posedge clk_i);
    #100;
    chk("R6 ready at timeout", ready_o, 1);
    chk("R6 error flag", tmo_err_o, 1);
    chk("R6 slow count zero", slow_cnt_o, 0);
    chk("R6 fast count zero", fast_cnt_o, 0);
    chk("R6 enables off", {slow_en_o, fast_en_o}, 0);
    pd_on = 1'b1;
    #10000;
    do_clear();

    // R7: normal conversion after an error
    js = exp_steps(1030);
    fire(1030);
    wait_ready("R7 ready after recovery");
    chk("R7 no error", tmo_err_o, 0);
    chk("R7 slow count", slow_cnt_o, js);
    chk("R7 fast count", fast_cnt_o, js);

    // R9: saturation
    @(negedge clk_i);
    for (int i = 0; i < 20; i++) pulse_trig();
    chk("R9 miss saturates", miss_cnt_o, (1 << MISS_W) - 1);
    do_clear();
    chk("R9 clear keeps miss", miss_cnt_o, (1 << MISS_W) - 1);
    rst_ni = 1'b0;
    #1000;
    chk("R9 reset clears miss", miss_cnt_o, 0);
    chk("R1 ready in reset", ready_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule